// File: doc/BRIEF.md
# Multi-Target Branch Address Cache

This block lets a fetch unit follow two predicted branches in one cycle. It is looked up with a single fetch address. Each entry holds a small tree of addresses: the taken and not-taken start addresses for the branch that ends the first basic block, and the four start addresses that follow a second branch on either path. The entry also holds a valid bit and a kind for the first branch and for each of the two possible second branches. A pair of direction bits from an external global-history predictor enters with the lookup address. These bits choose the path through the tree. The block then returns the start addresses of the second and third basic blocks.

A lookup presented in one cycle produces registered results two clock edges later. The first edge is the synchronous memory read and the second is the output register. A write port installs a whole tree for one address in a single cycle. The storage reads before it writes, so a lookup of the index being written in the same cycle sees the old contents. The index is taken from the address bits just above the line offset, and the tag is taken from the bits above the index. With the defaults, the line size is 16 bytes, the index is addr[9:4] and the tag is addr[31:10].

Top module: `tree_addr_cache`

## Requirements
- R1: After reset, o_vld and o_hit are 0 and every entry is empty, so the first lookup of any address reports a miss.
- R2: A lookup with lk_vld=1 at a clock edge gives o_vld=1 after the following edge, which is two edges in total. In every other cycle o_vld is 0.
- R3: When the tag misses, o_hit=0 and o_dir=00. o_blk2 is the next sequential line (the lookup address with its low 4 bits cleared, plus 16), and o_blk3 is the line after that.
- R4: On a hit whose first branch is valid, o_blk2 is the taken address when lk_pred[0]=1, and the not-taken address when lk_pred[0]=0. o_dir[0] reports the direction used.
- R5: On such a hit, when the chosen second branch is valid, o_blk3 is the taken-taken, taken-not-taken, not-taken-taken or not-taken-not-taken address, selected by the two directions. o_dir[1] reports the second direction.
- R6: On a hit whose first branch is not valid, o_hit=1 and o_dir=00, and the addresses are sequential as in R3.
- R7: When the second branch on the chosen path is not valid, o_blk3 is the line after o_blk2 (o_blk2 with its low 4 bits cleared, plus 16) and o_dir[1]=0.
- R8: The kind field is 2 bits wide: 0 conditional, 1 unconditional, 2 return, 3 reserved. A first branch of kind 1 takes the taken path whatever lk_pred[0] is.
- R9: A chosen second branch of kind 1 takes its taken path whatever lk_pred[1] is.
- R10: Branches of kind 0, 2 or 3 follow their prediction bit.
- R11: A lookup and a write to the same index in the same cycle return the contents from before the write. A lookup in the next cycle returns the new tree.
- R12: A lookup that maps to a written index but carries a different tag misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vld | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Fetch address to look up |
| lk_pred | input | 2 | Predicted directions: bit 0 is the first branch, bit 1 the second |
| wr_en | input | 1 | Install a tree |
| wr_addr | input | ADDR_W | Address whose index and tag are written |
| wr_p_vld | input | 1 | First branch present |
| wr_p_kind | input | 2 | First branch kind |
| wr_t_vld | input | 1 | Second branch present on the taken path |
| wr_t_kind | input | 2 | Its kind |
| wr_n_vld | input | 1 | Second branch present on the not-taken path |
| wr_n_kind | input | 2 | Its kind |
| wr_tgt_t | input | ADDR_W | First branch taken address |
| wr_tgt_n | input | ADDR_W | First branch not-taken address |
| wr_tgt_tt | input | ADDR_W | Taken then taken |
| wr_tgt_tn | input | ADDR_W | Taken then not taken |
| wr_tgt_nt | input | ADDR_W | Not taken then taken |
| wr_tgt_nn | input | ADDR_W | Not taken then not taken |
| o_vld | output | 1 | Result valid |
| o_hit | output | 1 | Tag matched a written entry |
| o_blk2 | output | ADDR_W | Start of the second basic block |
| o_blk3 | output | ADDR_W | Start of the third basic block |
| o_dir | output | 2 | Directions applied: bit 0 first, bit 1 second |

## Verification
The assertions assume that lk_vld and wr_en are held low while reset is high. They also assume that the kind inputs carry one of the four listed codes. The bench drives every input only after reset is released, with kinds drawn from the full 2-bit range. It uses a small pool of addresses so that index collisions and tag mismatches occur often. It also issues writes and lookups of the same index in the same cycle, both in directed steps and in the random phase.

// File: rtl/tac_pkg.sv
package tac_pkg;

  typedef enum logic [1:0] {
    BK_COND   = 2'd0,
    BK_UNCOND = 2'd1,
    BK_RET    = 2'd2,
    BK_RSVD   = 2'd3
  } br_kind_e;

  typedef struct packed {
    logic     pv;
    br_kind_e pk;
    logic     stv;
    br_kind_e stk;
    logic     snv;
    br_kind_e snk;
  } tree_ctl_t;

  localparam int NSLOT = 6;
  localparam int SL_T  = 0;
  localparam int SL_N  = 1;
  localparam int SL_TT = 2;
  localparam int SL_TN = 3;
  localparam int SL_NT = 4;
  localparam int SL_NN = 5;

endpackage

// File: rtl/tac_line_split.sv
module tac_line_split #(
  parameter int LN_W  = 28,
  parameter int IDX_W = 6,
  localparam int TAG_W = LN_W - IDX_W
) (
  input  logic [LN_W-1:0]  line,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  assign idx = line[IDX_W-1:0];
  assign tag = line[LN_W-1:IDX_W];
endmodule

// File: rtl/tac_store.sv
module tac_store
  import tac_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 22,
  parameter int ADDR_W = 32,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic                         rd_vld,
  output logic [TAG_W-1:0]             rd_tag,
  output tree_ctl_t                    rd_ctl,
  output logic [NSLOT-1:0][ADDR_W-1:0] rd_tgt,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [TAG_W-1:0]             wr_tag,
  input  tree_ctl_t                    wr_ctl,
  input  logic [NSLOT-1:0][ADDR_W-1:0] wr_tgt
);

  logic [DEPTH-1:0] vbits;
  logic [TAG_W-1:0] tag_mem [DEPTH];
  tree_ctl_t        ctl_mem [DEPTH];

  // Valid bits live in flops so that reset can clear them.
  always_ff @(posedge clk) begin
    if (rst) begin
      vbits  <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (rd_en) rd_vld <= vbits[rd_idx];
      if (wr_en) vbits[wr_idx] <= 1'b1;
    end
  end

  // Read-first RAM for the tag and the control fields.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      ctl_mem[wr_idx] <= wr_ctl;
    end
    if (rd_en) begin
      rd_tag <= tag_mem[rd_idx];
      rd_ctl <= ctl_mem[rd_idx];
    end
  end

  // One read-first RAM for each address slot of the tree.
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [ADDR_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_tgt[g];
      if (rd_en) rd_tgt[g] <= mem[rd_idx];
    end
  end

  AST_READ_OLD_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && rd_idx == wr_idx && !vbits[rd_idx]) |=> !rd_vld); // R11

endmodule

// File: rtl/tac_path_sel.sv
module tac_path_sel
  import tac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int TAG_W  = 22,
  localparam int LN_W  = ADDR_W - OFF_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_vld,
  input  logic [LN_W-1:0]              in_line,
  input  logic [TAG_W-1:0]             in_tag,
  input  logic [1:0]                   in_pred,
  input  logic                         ent_vld,
  input  logic [TAG_W-1:0]             ent_tag,
  input  tree_ctl_t                    ent_ctl,
  input  logic [NSLOT-1:0][ADDR_W-1:0] ent_tgt,
  output logic                         o_vld,
  output logic                         o_hit,
  output logic [ADDR_W-1:0]            o_blk2,
  output logic [ADDR_W-1:0]            o_blk3,
  output logic [1:0]                   o_dir
);

  function automatic logic [ADDR_W-1:0] next_line(input logic [ADDR_W-1:0] a);
    logic [LN_W-1:0] l;
    l = a[ADDR_W-1:OFF_W] + LN_W'(1);
    return {l, {OFF_W{1'b0}}};
  endfunction

  logic              hit_c, d1, d2, sec_v;
  br_kind_e          sec_k;
  logic [2:0]        slot3;
  logic [ADDR_W-1:0] fall, b2, nb2, nb3;
  logic [1:0]        ndir;

  always_comb begin
    hit_c = in_vld && ent_vld && (ent_tag == in_tag);
    fall  = {in_line + LN_W'(1), {OFF_W{1'b0}}};
    d1    = (ent_ctl.pk == BK_UNCOND) || in_pred[0];
    sec_v = d1 ? ent_ctl.stv : ent_ctl.snv;
    sec_k = d1 ? ent_ctl.stk : ent_ctl.snk;
    d2    = sec_v && ((sec_k == BK_UNCOND) || in_pred[1]);
    b2    = d1 ? ent_tgt[SL_T] : ent_tgt[SL_N];
    if (d1) slot3 = d2 ? 3'(SL_TT) : 3'(SL_TN);
    else    slot3 = d2 ? 3'(SL_NT) : 3'(SL_NN);
    if (hit_c && ent_ctl.pv) begin
      nb2  = b2;
      nb3  = sec_v ? ent_tgt[slot3] : next_line(b2);
      ndir = {d2, d1};
    end else begin
      nb2  = fall;
      nb3  = next_line(fall);
      ndir = 2'b00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld  <= 1'b0;
      o_hit  <= 1'b0;
      o_blk2 <= '0;
      o_blk3 <= '0;
      o_dir  <= 2'b00;
    end else begin
      o_vld  <= in_vld;
      o_hit  <= hit_c;
      o_blk2 <= nb2;
      o_blk3 <= nb3;
      o_dir  <= ndir;
    end
  end

  AST_LAT_ON: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> o_vld); // R2
  AST_LAT_OFF: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !o_vld); // R2
  AST_HIT_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
    o_hit |-> o_vld); // R3
  AST_MISS_NO_DIR: assert property (@(posedge clk) disable iff (rst)
    (o_vld && !o_hit) |-> (o_dir == 2'b00)); // R3
  AST_FORCE_PRIMARY: assert property (@(posedge clk) disable iff (rst)
    (hit_c && ent_ctl.pv && ent_ctl.pk == BK_UNCOND) |=> o_dir[0]); // R8

endmodule

// File: rtl/tree_addr_cache.sv
module tree_addr_cache
  import tac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 6,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_vld,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [1:0]        lk_pred,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_p_vld,
  input  logic [1:0]        wr_p_kind,
  input  logic              wr_t_vld,
  input  logic [1:0]        wr_t_kind,
  input  logic              wr_n_vld,
  input  logic [1:0]        wr_n_kind,
  input  logic [ADDR_W-1:0] wr_tgt_t,
  input  logic [ADDR_W-1:0] wr_tgt_n,
  input  logic [ADDR_W-1:0] wr_tgt_tt,
  input  logic [ADDR_W-1:0] wr_tgt_tn,
  input  logic [ADDR_W-1:0] wr_tgt_nt,
  input  logic [ADDR_W-1:0] wr_tgt_nn,
  output logic              o_vld,
  output logic              o_hit,
  output logic [ADDR_W-1:0] o_blk2,
  output logic [ADDR_W-1:0] o_blk3,
  output logic [1:0]        o_dir
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int LN_W  = ADDR_W - OFF_W;
  localparam int TAG_W = LN_W - IDX_W;

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag, s1_tag, ent_tag;
  logic             s1_vld, ent_vld;
  logic [LN_W-1:0]  s1_line;
  logic [1:0]       s1_pred;
  tree_ctl_t        wr_ctl, ent_ctl;
  logic [NSLOT-1:0][ADDR_W-1:0] wr_tgt, ent_tgt;
  logic             unused_low;

  assign unused_low = ^{lk_addr[OFF_W-1:0], wr_addr[OFF_W-1:0]};

  tac_line_split #(.LN_W(LN_W), .IDX_W(IDX_W)) u_lk_split (
    .line(lk_addr[ADDR_W-1:OFF_W]), .idx(lk_idx), .tag(lk_tag));
  tac_line_split #(.LN_W(LN_W), .IDX_W(IDX_W)) u_wr_split (
    .line(wr_addr[ADDR_W-1:OFF_W]), .idx(wr_idx), .tag(wr_tag));

  assign wr_ctl = '{pv:  wr_p_vld, pk:  br_kind_e'(wr_p_kind),
                    stv: wr_t_vld, stk: br_kind_e'(wr_t_kind),
                    snv: wr_n_vld, snk: br_kind_e'(wr_n_kind)};
  assign wr_tgt = {wr_tgt_nn, wr_tgt_nt, wr_tgt_tn, wr_tgt_tt, wr_tgt_n, wr_tgt_t};

  // Stage 1: the lookup context travels alongside the memory read.
  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= lk_vld;
    s1_line <= lk_addr[ADDR_W-1:OFF_W];
    s1_pred <= lk_pred;
  end
  assign s1_tag = s1_line[LN_W-1:IDX_W];

  tac_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_en(lk_vld), .rd_idx(lk_idx),
    .rd_vld(ent_vld), .rd_tag(ent_tag), .rd_ctl(ent_ctl), .rd_tgt(ent_tgt),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_ctl(wr_ctl), .wr_tgt(wr_tgt));

  // Stage 2: path selection and registered outputs.
  tac_path_sel #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .TAG_W(TAG_W)) u_sel (
    .clk(clk), .rst(rst),
    .in_vld(s1_vld), .in_line(s1_line), .in_tag(s1_tag), .in_pred(s1_pred),
    .ent_vld(ent_vld), .ent_tag(ent_tag), .ent_ctl(ent_ctl), .ent_tgt(ent_tgt),
    .o_vld(o_vld), .o_hit(o_hit), .o_blk2(o_blk2), .o_blk3(o_blk3), .o_dir(o_dir));

endmodule

// File: tb/tb_tree_addr_cache.sv
module tb_tree_addr_cache;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic lk_vld = 0, wr_en = 0;
  logic [31:0] lk_addr = 0, wr_addr = 0;
  logic [1:0] lk_pred = 0;
  logic wr_p_vld = 0, wr_t_vld = 0, wr_n_vld = 0;
  logic [1:0] wr_p_kind = 0, wr_t_kind = 0, wr_n_kind = 0;
  logic [31:0] wr_tgt_t = 0, wr_tgt_n = 0, wr_tgt_tt = 0, wr_tgt_tn = 0, wr_tgt_nt = 0, wr_tgt_nn = 0;
  logic o_vld, o_hit;
  logic [31:0] o_blk2, o_blk3;
  logic [1:0] o_dir;

  tree_addr_cache dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state
  bit          mv [DEPTH];
  int unsigned mtag [DEPTH];
  bit          mpv [DEPTH], mtv [DEPTH], mnv [DEPTH];
  int          mpk [DEPTH], mtk [DEPTH], mnk [DEPTH];
  logic [31:0] ma [DEPTH][6];

  // Two-deep expectation pipe
  bit e1_v = 0, e2_v = 0, e1_h = 0, e2_h = 0;
  logic [31:0] e1_b2 = 0, e2_b2 = 0, e1_b3 = 0, e2_b3 = 0;
  logic [1:0] e1_d = 0, e2_d = 0;
  string e1_r = "", e2_r = "", cur_req = "R1";

  function automatic logic [31:0] nl(input logic [31:0] a);
    return (a & 32'hFFFF_FFF0) + 32'd16;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", r, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit nv, nh; logic [31:0] nb2, nb3; logic [1:0] nd;
    int ix; int unsigned tg; bit d1, d2, sv; int sk;
    nv = lk_vld; nh = 0; nb2 = 0; nb3 = 0; nd = 0;
    if (lk_vld) begin
      ix = int'((lk_addr >> 4) & 32'h3F);
      tg = lk_addr >> 10;
      nh = mv[ix] && (mtag[ix] == tg);
      if (nh && mpv[ix]) begin
        d1 = (mpk[ix] == 1) || lk_pred[0];
        sv = d1 ? mtv[ix] : mnv[ix];
        sk = d1 ? mtk[ix] : mnk[ix];
        d2 = sv && ((sk == 1) || lk_pred[1]);
        nb2 = d1 ? ma[ix][0] : ma[ix][1];
        if (!sv)     nb3 = nl(nb2);
        else if (d1) nb3 = d2 ? ma[ix][2] : ma[ix][3];
        else         nb3 = d2 ? ma[ix][4] : ma[ix][5];
        nd = {d2, d1};
      end else begin
        nb2 = nl(lk_addr); nb3 = nl(nb2); nd = 0;
      end
    end
    if (wr_en) begin
      ix = int'((wr_addr >> 4) & 32'h3F);
      mv[ix] = 1; mtag[ix] = wr_addr >> 10;
      mpv[ix] = wr_p_vld; mpk[ix] = int'(wr_p_kind);
      mtv[ix] = wr_t_vld; mtk[ix] = int'(wr_t_kind);
      mnv[ix] = wr_n_vld; mnk[ix] = int'(wr_n_kind);
      ma[ix][0] = wr_tgt_t;  ma[ix][1] = wr_tgt_n;
      ma[ix][2] = wr_tgt_tt; ma[ix][3] = wr_tgt_tn;
      ma[ix][4] = wr_tgt_nt; ma[ix][5] = wr_tgt_nn;
    end
    @(posedge clk); #1;
    e2_v = e1_v; e2_h = e1_h; e2_b2 = e1_b2; e2_b3 = e1_b3; e2_d = e1_d; e2_r = e1_r;
    e1_v = nv; e1_h = nh; e1_b2 = nb2; e1_b3 = nb3; e1_d = nd; e1_r = cur_req;
    chk("R2", 32'(o_vld), 32'(e2_v), "o_vld");
    if (e2_v) begin
      chk(e2_r, 32'(o_hit), 32'(e2_h), "o_hit");
      chk(e2_r, o_blk2, e2_b2, "o_blk2");
      chk(e2_r, o_blk3, e2_b3, "o_blk3");
      chk(e2_r, 32'(o_dir), 32'(e2_d), "o_dir");
    end
    lk_vld = 0; wr_en = 0;
  endtask

  task automatic set_wr(input logic [31:0] a, input bit pv, input int pk,
                        input bit tv, input int tk, input bit nv, input int nk,
                        input logic [31:0] base);
    wr_en = 1; wr_addr = a;
    wr_p_vld = pv; wr_p_kind = 2'(pk);
    wr_t_vld = tv; wr_t_kind = 2'(tk);
    wr_n_vld = nv; wr_n_kind = 2'(nk);
    wr_tgt_t = base;            wr_tgt_n = base + 32'h104;
    wr_tgt_tt = base + 32'h208; wr_tgt_tn = base + 32'h30C;
    wr_tgt_nt = base + 32'h418; wr_tgt_nn = base + 32'h524;
  endtask

  task automatic set_lk(input logic [31:0] a, input logic [1:0] p);
    lk_vld = 1; lk_addr = a; lk_pred = p;
  endtask

  task automatic flush();
    repeat (3) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mv[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk("R1", 32'(o_vld), 0, "o_vld after reset");
    chk("R1", 32'(o_hit), 0, "o_hit after reset");

    cur_req = "R1"; set_lk(32'h0000_1234, 2'b11); tick(); flush();
    cur_req = "R3"; set_lk(32'h0000_5678, 2'b01); tick(); flush();

    // Full tree, conditional branches everywhere
    set_wr(32'h0000_1000, 1, 0, 1, 0, 1, 0, 32'h0002_0000); tick();
    cur_req = "R4"; set_lk(32'h0000_1004, 2'b00); tick(); set_lk(32'h0000_1008, 2'b01); tick();
    cur_req = "R5"; set_lk(32'h0000_1000, 2'b10); tick(); set_lk(32'h0000_100C, 2'b11); tick();
    flush();

    // Same-cycle write and lookup of one index
    cur_req = "R11";
    set_wr(32'h0000_1000, 1, 0, 1, 0, 1, 0, 32'h0003_0000); set_lk(32'h0000_1000, 2'b11); tick();
    set_lk(32'h0000_1000, 2'b11); tick();
    set_wr(32'h0000_2040, 1, 0, 1, 0, 1, 0, 32'h0004_0000); set_lk(32'h0000_2040, 2'b00); tick();
    flush();

    // Tag mismatch at an occupied index
    cur_req = "R12"; set_lk(32'h0000_5000, 2'b11); tick(); flush();

    // First branch absent
    set_wr(32'h0000_3080, 0, 0, 1, 0, 1, 0, 32'h0005_0000); tick();
    cur_req = "R6"; set_lk(32'h0000_3084, 2'b11); tick(); flush();

    // Second branch absent on the taken path only
    set_wr(32'h0000_30C0, 1, 0, 0, 1, 1, 0, 32'h0006_0000); tick();
    cur_req = "R7"; set_lk(32'h0000_30C0, 2'b11); tick();
    cur_req = "R5"; set_lk(32'h0000_30C0, 2'b10); tick(); flush();

    // Unconditional first branch
    set_wr(32'h0000_4100, 1, 1, 1, 0, 1, 0, 32'h0007_0000); tick();
    cur_req = "R8"; set_lk(32'h0000_4100, 2'b00); tick(); set_lk(32'h0000_4100, 2'b10); tick(); flush();

    // Unconditional second branch on the not-taken path
    set_wr(32'h0000_4140, 1, 0, 1, 0, 1, 1, 32'h0008_0000); tick();
    cur_req = "R9"; set_lk(32'h0000_4140, 2'b00); tick(); flush();

    // Return and reserved kinds follow the prediction
    set_wr(32'h0000_4180, 1, 2, 1, 3, 1, 2, 32'h0009_0000); tick();
    cur_req = "R10"; set_lk(32'h0000_4180, 2'b00); tick(); set_lk(32'h0000_4180, 2'b11); tick();
    set_lk(32'h0000_4180, 2'b01); tick(); flush();

    // Random mix over a small pool to force collisions
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      if (($urandom % 3) == 0) begin
        a = ((($urandom % 2) << 10) | (($urandom % 4) << 4));
        set_wr(a, 1'($urandom), int'($urandom % 4), 1'($urandom), int'($urandom % 4),
               1'($urandom), int'($urandom % 4), $urandom & 32'h00FF_FFFC);
      end
      if (($urandom % 3) != 0) begin
        a = ((($urandom % 2) << 10) | (($urandom % 4) << 4) | ($urandom % 16));
        set_lk(a, 2'($urandom));
      end
      tick();
    end
    flush();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule